// File: doc/BRIEF.md
# Circulating-Current Correction Modulator

This block drives the two full-bridge correction modules of one converter phase leg. Every carrier period it samples the top and bottom arm currents, the dc-link current and both correction-capacitor voltages as signed 16-bit fixed-point values. It forms the leg's circulating current as the mean of the two arm currents and regulates it towards one third of the dc-link current with a proportional gain. Half of that proportional term goes to each module. Each module then adds its own proportional-integral term, which holds its capacitor at a common setpoint. The sign of that term follows the polarity of the module's own arm current.

Each of the two references is compared with a shared triangle carrier, using the reference and its negation, to produce a three-level module state. The carrier is driven by a small state machine with three states. CAR_HOLD holds the count at zero while the block is bypassed. CAR_UP counts upwards. CAR_DOWN counts downwards. The transitions are: CAR_HOLD to CAR_UP on enable; CAR_UP to CAR_DOWN when the count reaches the peak; CAR_DOWN to CAR_UP when the count reaches zero; any state to CAR_HOLD when enable is low. Each module state is one of MS_ZERO (2'b00), MS_POS (2'b01) or MS_NEG (2'b11).

The references and integrators change only at the carrier peak, so a reference update cannot split a switching period. Gains, setpoint and integrator limit come in as register values. All gains are Q8, with 256 representing 1.0.

Top module: `ccm_leg`

## Requirements
- R1: While `rst_n` is low, `carrier` is 0, both module states are MS_ZERO, and both integrators and both references are cleared.
- R2: When enabled, `carrier` follows a triangle between 0 and CAR_MAX in steps of exactly one, through CAR_HOLD, CAR_UP and CAR_DOWN. After enable rises, the count stays at 0 for one further cycle before it starts rising.
- R3: References and integrators update only on the clock edge at which `carrier` equals CAR_MAX in CAR_DOWN (the peak), using the inputs present at that edge. Input changes at any other time have no effect until the next peak.
- R4: Circulating term: icir = (i_arm_top + i_arm_bot) >>> 1 and iref = i_link / 3, truncated toward zero. The error is err = sat(iref − icir). The proportional output is p = sat((kp_cc·err) >>> 8), and h = p >>> 1 is added to both references.
- R5: Per module: ev = sat(v_set − v_cap). The integrator becomes I' = clamp(I + ((ki_v·ev) >>> 8)). The PI output is pi = sat(((kp_v·ev) >>> 8) + I').
- R6: pi is used unchanged when that module's arm current is ≥ 0. It is replaced by sat(−pi) when the arm current is negative.
- R7: Each new reference is sat(h + signed pi).
- R8: Module state is MS_POS when ref > carrier, MS_NEG when −ref > carrier, and MS_ZERO otherwise.
- R9: After every update, each integrator lies within ±int_lim.
- R10: Every intermediate result saturates to [−32768, 32767], including the negation of −32768.
- R11: With `en` low, both states are MS_ZERO at once. Integrators, references and carrier are cleared at the next edge, so after re-enable the PI restarts from an empty integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | 1 = regulate, 0 = bypass |
| i_arm_top | input | 16 | Top arm current, signed |
| i_arm_bot | input | 16 | Bottom arm current, signed |
| i_link | input | 16 | Dc-link current, signed |
| v_cap_top | input | 16 | Top correction-capacitor voltage, signed |
| v_cap_bot | input | 16 | Bottom correction-capacitor voltage, signed |
| v_set | input | 16 | Capacitor voltage setpoint, signed |
| kp_cc | input | 16 | Circulating-current proportional gain, Q8 signed |
| kp_v | input | 16 | Capacitor proportional gain, Q8 signed |
| ki_v | input | 16 | Capacitor integral gain, Q8 signed |
| int_lim | input | 15 | Integrator magnitude limit |
| carrier | output | CW | Triangle carrier count |
| mstate_top | output | 2 | Top module state |
| mstate_bot | output | 2 | Bottom module state |

## Verification
Some properties are checked by assertions on every cycle:
- the carrier's range and its unit step;
- that the references hold steady away from the peak;
- the integrator limit after each update;
- the clearing of state while bypassed;
- that a non-zero module state always agrees in sign and size with its reference against the carrier.

The arithmetic chain cannot be checked that way. This covers the divide by three, the halving, the sign flip on negative arm current, saturation at the 16-bit limits, and integrator accumulation over several periods. These are shown only by the bench scenarios, which predict every state of every cycle from the requirement formulas.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    localparam int DW   = 16;
    localparam int FRAC = 8;
    localparam int WIDE = 2*DW + 4;

    typedef logic signed [DW-1:0]   samp_t;
    typedef logic signed [WIDE-1:0] wide_t;

    typedef enum logic [1:0] {
        CAR_HOLD = 2'd0,
        CAR_UP   = 2'd1,
        CAR_DOWN = 2'd2
    } car_state_e;

    typedef enum logic [1:0] {
        MS_ZERO = 2'b00,
        MS_POS  = 2'b01,
        MS_NEG  = 2'b11
    } mstate_e;

    function automatic wide_t ext(input samp_t v);
        return wide_t'(v);
    endfunction

    function automatic samp_t sat(input wide_t x);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (DW-1)) - wide_t'(1);
        lo = -hi - wide_t'(1);
        if (x > hi)
            return samp_t'(hi);
        else if (x < lo)
            return samp_t'(lo);
        else
            return x[DW-1:0];
    endfunction

endpackage

// File: rtl/ccm_carrier.sv
module ccm_carrier
    import ccm_pkg::*;
#(
    parameter int CAR_MAX = 25000,
    parameter int CW      = $clog2(CAR_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          peak
);

    localparam logic [CW-1:0] TOP    = CW'(CAR_MAX);
    localparam logic [CW-1:0] TOP_M1 = CW'(CAR_MAX - 1);

    car_state_e    st, st_n;
    logic [CW-1:0] cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CAR_HOLD;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (!en) begin
            st_n  = CAR_HOLD;
            cnt_n = '0;
        end else begin
            unique case (st)
                CAR_HOLD: begin
                    st_n  = CAR_UP;
                    cnt_n = '0;
                end
                CAR_UP: begin
                    cnt_n = cnt + CW'(1);
                    if (cnt == TOP_M1) st_n = CAR_DOWN;
                end
                CAR_DOWN: begin
                    cnt_n = cnt - CW'(1);
                    if (cnt == CW'(1)) st_n = CAR_UP;
                end
                default: begin
                    st_n  = CAR_HOLD;
                    cnt_n = '0;
                end
            endcase
        end
    end

    assign peak = en && (st == CAR_DOWN) && (cnt == TOP);

    // R2: the count never leaves [0, CAR_MAX]
    a_r2_carrier_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    // R2: successive enabled counts differ by exactly one, or stay at zero after enable
    a_r2_carrier_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |->
            ((cnt == $past(cnt) + CW'(1)) || (cnt == $past(cnt) - CW'(1)) ||
             ((cnt == '0) && ($past(cnt) == '0))));

endmodule

// File: rtl/ccm_capreg.sv
module ccm_capreg
    import ccm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          peak,
    input  samp_t         v_cap,
    input  samp_t         i_arm,
    input  samp_t         v_set,
    input  samp_t         kp_v,
    input  samp_t         ki_v,
    input  logic [DW-2:0] int_lim,
    input  samp_t         half_cc,
    output samp_t         ref_o
);

    samp_t integ, integ_n;
    samp_t ev, pi, spi, ref_n;
    wide_t inc, isum, lim, pterm;

    always_comb begin
        ev    = sat(ext(v_set) - ext(v_cap));
        inc   = (ext(ki_v) * ext(ev)) >>> FRAC;
        isum  = ext(integ) + inc;
        lim   = wide_t'({1'b0, int_lim});
        if (isum > lim)
            integ_n = samp_t'(lim);
        else if (isum < -lim)
            integ_n = samp_t'(-lim);
        else
            integ_n = isum[DW-1:0];
        pterm = (ext(kp_v) * ext(ev)) >>> FRAC;
        pi    = sat(pterm + ext(integ_n));
        spi   = (i_arm < 0) ? sat(-ext(pi)) : pi;
        ref_n = sat(ext(half_cc) + ext(spi));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            integ <= '0;
            ref_o <= '0;
        end else if (peak) begin
            integ <= integ_n;
            ref_o <= ref_n;
        end
    end

    // R3: reference frozen unless the previous cycle was the carrier peak
    a_r3_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(peak)) |-> $stable(ref_o));

    // R9: integrator inside the limit after an update
    a_r9_integ_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(peak)) |->
            ((ext(integ) <= wide_t'({1'b0, $past(int_lim)})) &&
             (ext(integ) >= -wide_t'({1'b0, $past(int_lim)}))));

    // R11: bypass clears integrator and reference at the next edge
    a_r11_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> ((integ == '0) && (ref_o == '0)));

endmodule

// File: rtl/ccm_pwm3.sv
module ccm_pwm3
    import ccm_pkg::*;
#(
    parameter int CW = 15
) (
    input  logic          en,
    input  samp_t         ref_i,
    input  logic [CW-1:0] car,
    output logic [1:0]    mstate
);

    wide_t refw, carw;

    always_comb begin
        refw = ext(ref_i);
        carw = wide_t'({{(WIDE-CW){1'b0}}, car});
        if (!en)
            mstate = MS_ZERO;
        else if (refw > carw)
            mstate = MS_POS;
        else if (-refw > carw)
            mstate = MS_NEG;
        else
            mstate = MS_ZERO;
    end

endmodule

// File: rtl/ccm_leg.sv
module ccm_leg
    import ccm_pkg::*;
#(
    parameter int CAR_MAX = 25000,
    parameter int CW      = $clog2(CAR_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [15:0]   i_arm_top,
    input  logic signed [15:0]   i_arm_bot,
    input  logic signed [15:0]   i_link,
    input  logic signed [15:0]   v_cap_top,
    input  logic signed [15:0]   v_cap_bot,
    input  logic signed [15:0]   v_set,
    input  logic signed [15:0]   kp_cc,
    input  logic signed [15:0]   kp_v,
    input  logic signed [15:0]   ki_v,
    input  logic        [14:0]   int_lim,
    output logic        [CW-1:0] carrier,
    output logic        [1:0]    mstate_top,
    output logic        [1:0]    mstate_bot
);

    localparam int NMOD = 2;

    logic  peak;
    wide_t icir, iref, pw;
    samp_t err, p_cc, half_cc;

    samp_t      v_arr [NMOD];
    samp_t      i_arr [NMOD];
    samp_t      r_arr [NMOD];
    logic [1:0] m_arr [NMOD];

    ccm_carrier #(.CAR_MAX(CAR_MAX), .CW(CW)) u_car (
        .clk (clk),
        .rst_n(rst_n),
        .en  (en),
        .cnt (carrier),
        .peak(peak)
    );

    always_comb begin
        icir    = (ext(i_arm_top) + ext(i_arm_bot)) >>> 1;
        iref    = ext(i_link) / $signed(wide_t'(3));
        err     = sat(iref - icir);
        pw      = (ext(kp_cc) * ext(err)) >>> FRAC;
        p_cc    = sat(pw);
        half_cc = p_cc >>> 1;
    end

    assign v_arr[0] = v_cap_top;
    assign v_arr[1] = v_cap_bot;
    assign i_arr[0] = i_arm_top;
    assign i_arr[1] = i_arm_bot;

    for (genvar g = 0; g < NMOD; g++) begin : g_mod
        ccm_capreg u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .peak   (peak),
            .v_cap  (v_arr[g]),
            .i_arm  (i_arr[g]),
            .v_set  (v_set),
            .kp_v   (kp_v),
            .ki_v   (ki_v),
            .int_lim(int_lim),
            .half_cc(half_cc),
            .ref_o  (r_arr[g])
        );

        ccm_pwm3 #(.CW(CW)) u_pwm (
            .en    (en),
            .ref_i (r_arr[g]),
            .car   (carrier),
            .mstate(m_arr[g])
        );

        // R8: a non-zero state agrees with the reference against the carrier
        a_r8_state_match: assert property (@(posedge clk) disable iff (!rst_n)
            ((m_arr[g] == MS_POS) |-> (ext(r_arr[g]) > wide_t'({1'b0, carrier}))) and
            ((m_arr[g] == MS_NEG) |-> (-ext(r_arr[g]) > wide_t'({1'b0, carrier}))));

        // R8: the unused code 2'b10 never appears
        a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
            m_arr[g] != 2'b10);

        // R11: bypass forces the zero state
        a_r11_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> (m_arr[g] == MS_ZERO));
    end

    assign mstate_top = m_arr[0];
    assign mstate_bot = m_arr[1];

endmodule

// File: tb/test_ccm_leg.sv
module test_ccm_leg;

    localparam int M  = 50;
    localparam int CW = $clog2(M + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic signed [15:0] i_arm_top = 0, i_arm_bot = 0, i_link = 0;
    logic signed [15:0] v_cap_top = 0, v_cap_bot = 0, v_set = 0;
    logic signed [15:0] kp_cc = 0, kp_v = 0, ki_v = 0;
    logic [14:0] int_lim = 0;
    logic [CW-1:0] carrier;
    logic [1:0] mstate_top, mstate_bot;

    ccm_leg #(.CAR_MAX(M)) i_ccm_leg (
        .clk(clk), .rst_n(rst_n), .en(en),
        .i_arm_top(i_arm_top), .i_arm_bot(i_arm_bot), .i_link(i_link),
        .v_cap_top(v_cap_top), .v_cap_bot(v_cap_bot), .v_set(v_set),
        .kp_cc(kp_cc), .kp_v(kp_v), .ki_v(ki_v), .int_lim(int_lim),
        .carrier(carrier), .mstate_top(mstate_top), .mstate_bot(mstate_bot)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    int m_car = 0, m_dir = 0;
    longint m_ref [2];
    longint m_int [2];

    function automatic longint sat16(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic int exp_state(longint r, int c, bit e);
        if (!e) return 0;
        if (r > c) return 1;
        if (-r > c) return -1;
        return 0;
    endfunction

    function automatic int dec(logic [1:0] s);
        case (s)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return -1;
            default: return 99;
        endcase
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            if (n_fail < 30)
                $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        longint icir, iref, err, p, h, ev, inc, s, pt, pi, spi, lim;
        longint va [2];
        longint ia [2];
        va[0] = v_cap_top; va[1] = v_cap_bot;
        ia[0] = i_arm_top; ia[1] = i_arm_bot;
        icir = (longint'(i_arm_top) + longint'(i_arm_bot)) >>> 1;
        iref = longint'(i_link) / 3;
        err  = sat16(iref - icir);
        p    = sat16((longint'(kp_cc) * err) >>> 8);
        h    = p >>> 1;
        lim  = longint'(int_lim);
        for (int k = 0; k < 2; k++) begin
            ev  = sat16(longint'(v_set) - va[k]);
            inc = (longint'(ki_v) * ev) >>> 8;
            s   = m_int[k] + inc;
            if (s > lim) s = lim;
            if (s < -lim) s = -lim;
            m_int[k] = s;
            pt  = (longint'(kp_v) * ev) >>> 8;
            pi  = sat16(pt + s);
            spi = (ia[k] < 0) ? sat16(-pi) : pi;
            m_ref[k] = sat16(h + spi);
        end
    endtask

    task automatic tick(string tag);
        if (!rst_n || !en) begin
            m_car = 0; m_dir = 0;
            m_ref[0] = 0; m_ref[1] = 0; m_int[0] = 0; m_int[1] = 0;
        end else begin
            if (m_dir == 2 && m_car == M) model_update();
            case (m_dir)
                0: begin m_dir = 1; m_car = 0; end
                1: begin if (m_car == M-1) m_dir = 2; m_car++; end
                default: begin if (m_car == 1) m_dir = 1; m_car--; end
            endcase
        end
        @(negedge clk);
        check("R2 carrier", carrier, m_car);
        check({tag, "/R8 top"}, dec(mstate_top), exp_state(m_ref[0], m_car, en && rst_n));
        check({tag, "/R8 bot"}, dec(mstate_bot), exp_state(m_ref[1], m_car, en && rst_n));
    endtask

    task automatic run(string tag, int n);
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    function automatic logic signed [15:0] rnd(int lo, int hi);
        return 16'(int'($urandom_range(0, hi - lo)) + lo);
    endfunction

    task automatic rand_inputs(int ispan, int vspan);
        i_arm_top = rnd(-ispan, ispan);
        i_arm_bot = rnd(-ispan, ispan);
        i_link    = rnd(-3*ispan, 3*ispan);
        v_cap_top = rnd(200 - vspan, 200 + vspan);
        v_cap_bot = rnd(200 - vspan, 200 + vspan);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ref[0] = 0; m_ref[1] = 0; m_int[0] = 0; m_int[1] = 0;
        @(negedge clk);

        // R1: reset with enable asserted
        en = 1'b1; kp_cc = 256; i_link = 300;
        run("R1", 5);
        check("R1 carrier", carrier, 0);
        check("R1 top", dec(mstate_top), 0);

        // R11: bypass after reset
        rst_n = 1'b1; en = 1'b0;
        run("R11", 5);

        // R4: proportional path only: icir 15, iref 30, err 15, p 15, h 7
        kp_cc = 256; kp_v = 0; ki_v = 0; int_lim = 1000;
        i_arm_top = 20; i_arm_bot = 10; i_link = 90; v_set = 200;
        v_cap_top = 200; v_cap_bot = 200;
        en = 1'b1;
        run("R4", 3*2*M);
        for (int k = 0; k < 6; k++) begin
            kp_cc = rnd(0, 600);
            i_arm_top = rnd(-60, 60); i_arm_bot = rnd(-60, 60); i_link = rnd(-200, 200);
            run("R4", 2*M);
        end

        // R5: capacitor PI with positive arm currents
        kp_cc = 0; kp_v = 128; ki_v = 64; int_lim = 1000;
        i_arm_top = 5; i_arm_bot = 0; i_link = 0;
        v_cap_top = 180; v_cap_bot = 230;
        run("R5", 6*2*M);

        // R6: negative arm currents flip the PI sign
        i_arm_top = -5; i_arm_bot = -40;
        run("R6", 6*2*M);

        // R9: integrator driven into its limit
        kp_v = 0; ki_v = 2000; int_lim = 20; i_arm_top = 3; i_arm_bot = -3;
        v_cap_top = 0; v_cap_bot = 400;
        run("R9", 5*2*M);

        // R10: saturation of the proportional path
        en = 1'b0; run("R10", 2); en = 1'b1;
        kp_v = 0; ki_v = 0;
        i_arm_top = 32767; i_arm_bot = 32767; i_link = -32768; kp_cc = 32767;
        run("R10", 3*2*M);
        // R10: negation of -32768 on a negative arm current
        kp_cc = 0; kp_v = 32767; v_set = -32768; v_cap_top = 32767; v_cap_bot = 32767;
        i_arm_top = -1; i_arm_bot = 1;
        run("R10", 3*2*M);
        v_set = 200;

        // R3: inputs change every cycle; only peak-edge values count
        kp_cc = 200; kp_v = 100; ki_v = 30; int_lim = 500;
        for (int k = 0; k < 5*2*M; k++) begin
            rand_inputs(60, 40);
            tick("R3");
        end

        // R7: combined paths, random per period
        for (int k = 0; k < 40; k++) begin
            rand_inputs(50, 30);
            kp_cc = rnd(0, 512); kp_v = rnd(0, 300); ki_v = rnd(0, 100);
            int_lim = 15'($urandom_range(0, 60));
            run("R7", 2*M);
        end

        // R11: bypass mid-period with loaded integrators, then restart from empty
        kp_cc = 0; kp_v = 0; ki_v = 256; int_lim = 40;
        i_arm_top = 1; i_arm_bot = 1; v_cap_top = 190; v_cap_bot = 195;
        run("R11", 3*2*M + 17);
        en = 1'b0;
        run("R11", 20);
        check("R11 carrier cleared", carrier, 0);
        en = 1'b1;
        run("R11", 3*2*M);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule